// File: doc/BRIEF.md
# Gated IF Frequency Counter

This block measures an intermediate frequency by counting rising edges of a pulse input during a gate window of known length. A level control bit starts a measurement when it is set and clears the result when it is dropped. After a start, the block waits a settling time so the input can stabilise. It then opens the gate and counts edges. When the gate closes it presents the final count with a done flag.

All timing comes from an external one-cycle millisecond tick, so the block is purely digital. A 2-bit gate code selects both the window length and the settling wait. The code is captured when the measurement starts. An inhibit input stops the counter whenever it is high. The edge count divided by the window length gives the input frequency.

Top module: `if_gate_counter`

## Requirements
- R1: After reset, `count_o` is 0 and `done_o` is 0.
- R2: When `meas_en` is high, the block is idle and `inhibit` is low, a measurement starts at the next clock edge. `gate_sel` is captured at that edge, and later changes to it have no effect on the running measurement. Whenever `meas_en` is low, the next edge returns the block to idle with `count_o` at 0 and `done_o` at 0.
- R3: The settling wait lasts 4 `ms_tick` pulses for gate codes 00 and 01, and 8 pulses for codes 10 and 11. Edges that occur during the wait are not counted, and `count_o` stays 0.
- R4: The gate window lasts 4, 8, 32 or 64 `ms_tick` pulses for gate codes 00, 01, 10 and 11 respectively. `done_o` rises at the clock edge that samples the final tick of the window.
- R5: Rising edges of `if_in` pass through a two-flop synchronizer and are counted one per edge inside the window. An edge that reaches the counter in the same cycle as the final window tick is counted. An edge that arrives later is not counted.
- R6: While `done_o` is high, `count_o` holds its final value and further edges and ticks are ignored. This lasts until `meas_en` goes low.
- R7: `count_o` saturates at 2^CNT_W-1 and never wraps.
- R8: While `inhibit` is high, the next edge forces idle with `count_o` 0 and `done_o` 0, and no measurement can start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| if_in | input | 1 | IF pulse input, asynchronous |
| meas_en | input | 1 | Start (1) / reset (0) control level |
| gate_sel | input | 2 | Gate-time code |
| inhibit | input | 1 | Stops and clears the counter |
| ms_tick | input | 1 | One-cycle millisecond strobe |
| count_o | output | CNT_W | Edge count |
| done_o | output | 1 | Measurement complete |

## Verification
The closing tick of the gate and a synchronized input edge can reach the counter in the same cycle. In that case the edge is counted and the window closes together. The bench provokes this by timing an input pulse so that its synchronized edge lands exactly in the cycle that samples the last tick, and it expects the count to include that edge. It then moves the pulse so that it rises alongside the last tick, which makes its edge arrive only after the window has closed, and it expects the count to exclude it.

// File: rtl/if_gate_counter.sv
module if_gate_counter #(
  parameter int CNT_W = 20
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             if_in,
  input  logic             meas_en,
  input  logic [1:0]       gate_sel,
  input  logic             inhibit,
  input  logic             ms_tick,
  output logic [CNT_W-1:0] count_o,
  output logic             done_o
);

  localparam int TMR_W = 7;
  localparam logic [CNT_W-1:0] CNT_MAX = '1;

  typedef enum logic [1:0] {S_IDLE, S_WAIT, S_COUNT, S_DONE} state_t;

  state_t           state_q;
  logic [2:0]       sync_q;
  logic [1:0]       gate_q;
  logic [TMR_W-1:0] timer_q;
  logic [CNT_W-1:0] cnt_q;
  logic [TMR_W-1:0] wait_len, win_len;
  logic             if_rise;

  assign if_rise  = sync_q[1] & ~sync_q[2];
  assign wait_len = gate_q[1] ? TMR_W'(8) : TMR_W'(4);
  assign count_o  = cnt_q;
  assign done_o   = (state_q == S_DONE);

  always_comb begin
    case (gate_q)
      2'b00:   win_len = TMR_W'(4);
      2'b01:   win_len = TMR_W'(8);
      2'b10:   win_len = TMR_W'(32);
      default: win_len = TMR_W'(64);
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) sync_q <= '0;
    else        sync_q <= {sync_q[1:0], if_in};
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= S_IDLE;
      gate_q  <= '0;
      timer_q <= '0;
      cnt_q   <= '0;
    end else if (inhibit || !meas_en) begin
      state_q <= S_IDLE;
      timer_q <= '0;
      cnt_q   <= '0;
    end else begin
      case (state_q)
        S_IDLE: begin
          state_q <= S_WAIT;
          gate_q  <= gate_sel;
          timer_q <= '0;
          cnt_q   <= '0;
        end
        S_WAIT: if (ms_tick) begin
          if (timer_q == wait_len - 1'b1) begin
            state_q <= S_COUNT;
            timer_q <= '0;
          end else begin
            timer_q <= timer_q + 1'b1;
          end
        end
        S_COUNT: begin
          if (if_rise && cnt_q != CNT_MAX) cnt_q <= cnt_q + 1'b1;
          if (ms_tick) begin
            if (timer_q == win_len - 1'b1) state_q <= S_DONE;
            else                           timer_q <= timer_q + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  AST_STOP_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    !meas_en |=> (count_o == '0 && !done_o)); // R2

  AST_WAIT_NO_COUNT: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == S_WAIT) |=> (count_o == '0)); // R3

  AST_DONE_ON_TICK: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(done_o) |-> $past(ms_tick)); // R4

  AST_DONE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (done_o && meas_en && !inhibit) |=> (done_o && $stable(count_o))); // R6

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    (count_o == CNT_MAX && (state_q == S_COUNT || done_o) && meas_en && !inhibit)
      |=> (count_o == CNT_MAX)); // R7

  AST_INHIBIT_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
    inhibit |=> (count_o == '0 && !done_o)); // R8

endmodule

// File: tb/if_gate_counter_test.sv
module if_gate_counter_test;
  localparam int CLK_PERIOD = 10;
  localparam int W = 6;
  localparam int MAXV = (1 << W) - 1;
  localparam int NV = 6;
  localparam int V_CODE [NV] = '{0, 1, 2, 3, 0, 2};
  localparam int V_ALT  [NV] = '{3, 2, 0, 1, 1, 3};
  localparam int V_PRE  [NV] = '{2, 0, 3, 1, 0, 4};
  localparam int V_WIN  [NV] = '{5, 17, 40, 9, 0, 63};
  localparam int V_POST [NV] = '{3, 4, 2, 0, 5, 1};

  logic clk = 0, rst_n = 0, if_in = 0, meas_en = 0, inhibit = 0, ms_tick = 0;
  logic [1:0] gate_sel = 0;
  logic [W-1:0] count_o;
  logic done_o;
  int checks = 0, errors = 0;

  if_gate_counter #(.CNT_W(W)) uut (
    .clk(clk), .rst_n(rst_n), .if_in(if_in), .meas_en(meas_en),
    .gate_sel(gate_sel), .inhibit(inhibit), .ms_tick(ms_tick),
    .count_o(count_o), .done_o(done_o));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic step(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic tick_once();
    ms_tick = 1; @(negedge clk); ms_tick = 0;
  endtask

  task automatic do_ticks(int n);
    for (int i = 0; i < n; i++) begin tick_once(); step(2); end
  endtask

  task automatic emit(int n);
    for (int i = 0; i < n; i++) begin
      if_in = 1; @(negedge clk); if_in = 0; @(negedge clk);
    end
  endtask

  function automatic int win_of(int c);
    return (c == 0) ? 4 : (c == 1) ? 8 : (c == 2) ? 32 : 64;
  endfunction

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    step(3);
    chk("R1 count after reset", int'(count_o), 0);
    chk("R1 done after reset", int'(done_o), 0);
    rst_n = 1;
    step(2);

    for (int v = 0; v < NV; v++) begin
      int wl, wn, exp;
      wl = (V_CODE[v] >= 2) ? 8 : 4;
      wn = win_of(V_CODE[v]);
      exp = (V_WIN[v] > MAXV) ? MAXV : V_WIN[v];
      gate_sel = 2'(V_CODE[v]); meas_en = 1;
      @(negedge clk);
      gate_sel = 2'(V_ALT[v]);        // R2: must be ignored
      do_ticks(wl - 1);
      emit(V_PRE[v]); step(5);        // R3: edges in wait ignored
      chk("R3 count in wait", int'(count_o), 0);
      tick_once(); step(2);
      for (int k = 0; k < wn; k++) begin
        if (k == 0) begin emit(V_WIN[v]); step(4); end
        if (k == wn - 1) chk("R4 done before last tick", int'(done_o), 0);
        tick_once();
        if (k != wn - 1) step(2);
      end
      chk("R4 done after last tick", int'(done_o), 1);
      chk("R5 window count", int'(count_o), exp);
      emit(V_POST[v]); tick_once(); step(4);
      chk("R6 count held", int'(count_o), exp);
      chk("R6 done held", int'(done_o), 1);
      meas_en = 0; @(negedge clk);
      chk("R2 clear count", int'(count_o), 0);
      chk("R2 clear done", int'(done_o), 0);
      step(2);
    end

    // R5: edge reaches counter on the final tick cycle
    gate_sel = 0; meas_en = 1; @(negedge clk);
    do_ticks(4); emit(2); step(4); do_ticks(3);
    if_in = 1; @(negedge clk); if_in = 0; @(negedge clk);
    ms_tick = 1; @(negedge clk); ms_tick = 0;
    chk("R5 coincident edge counted", int'(count_o), 3);
    chk("R4 done coincident", int'(done_o), 1);
    meas_en = 0; step(3);

    // R5: edge rising with the final tick arrives late
    meas_en = 1; @(negedge clk);
    do_ticks(4); emit(2); step(4); do_ticks(3);
    ms_tick = 1; if_in = 1; @(negedge clk); ms_tick = 0; if_in = 0; step(4);
    chk("R5 late edge ignored", int'(count_o), 2);
    meas_en = 0; step(3);

    // R7 saturation
    meas_en = 1; @(negedge clk);
    do_ticks(4); emit(MAXV + 7); step(4); do_ticks(4);
    chk("R7 saturated count", int'(count_o), MAXV);
    chk("R7 done", int'(done_o), 1);
    meas_en = 0; step(3);

    // R8 inhibit mid-window, then restart
    gate_sel = 1; meas_en = 1; @(negedge clk);
    do_ticks(4); emit(5); step(4); do_ticks(2);
    inhibit = 1; @(negedge clk);
    chk("R8 inhibit clears count", int'(count_o), 0);
    do_ticks(8); emit(3); step(4);
    chk("R8 inhibit no done", int'(done_o), 0);
    chk("R8 inhibit no count", int'(count_o), 0);
    inhibit = 0; @(negedge clk);
    do_ticks(4); emit(3); step(4); do_ticks(8);
    chk("R8 restart count", int'(count_o), 3);
    chk("R8 restart done", int'(done_o), 1);
    meas_en = 0; step(3);

    // R8 inhibit blocks start
    inhibit = 1; meas_en = 1; gate_sel = 0; step(2);
    do_ticks(10); emit(4); step(4); do_ticks(10);
    chk("R8 blocked done", int'(done_o), 0);
    chk("R8 blocked count", int'(count_o), 0);
    inhibit = 0; meas_en = 0; step(3);

    // R2 stop mid-window
    meas_en = 1; @(negedge clk);
    do_ticks(4); emit(6); step(4);
    chk("R5 partial count", int'(count_o), 6);
    meas_en = 0; @(negedge clk);
    chk("R2 stop clears count", int'(count_o), 0);
    step(3);

    finish_run();
  end
endmodule